// File: doc/BRIEF.md
# Reorder Buffer with Incremental Squash

This block keeps in-flight instructions in program order in a circular store. Each slot holds a sequence number, a PC, a next-PC, a commit-ready flag and a squashed flag. One instruction can enter at the tail in each cycle. One instruction can leave from the head in each cycle, and only when the head slot is commit-ready. The execution side sets a slot's commit-ready flag through a write port indexed by slot number.

A squash request carries a sequence number and does not reset the pointers. Starting at the tail, the block walks toward the head over several cycles and examines at most `SQ_W` slots per cycle. Each slot it passes is marked squashed and commit-ready, so younger work drains through ordinary retirement. The walk ends when it meets the slot that holds the squash sequence number. It also ends once it has marked the head slot, which covers the case where the matching instruction has already left. No insertion or retirement happens while a walk is in progress.

Top module: `rob_core`

## Requirements
- R1: After reset, `free_cnt` equals `DEPTH`, `head_ready` is 0, `sq_done` is 1 and `ins_ready` is 1.
- R2: An accepted insert (`ins_valid` with `ins_ready`) writes the instruction after the current tail, or at the head slot when the store is empty. `free_cnt` then drops by one, `tail_seq`/`tail_pc` show the new instruction, and the head outputs show the oldest instruction present.
- R3: When the store holds `DEPTH` entries, `ins_ready` is 0, and an insert presented then changes neither `free_cnt` nor the tail outputs.
- R4: `head_ready` is 0 while the store is empty, and otherwise equals the head slot's commit-ready flag. A write through `rdy_set`/`rdy_idx` sets that flag for the slot index given, counted from 0 in insertion order modulo `DEPTH`.
- R5: With `ret_en` high and `head_ready` high, the head entry leaves, the head outputs advance to the next entry and `free_cnt` rises by one. With `head_ready` low, `ret_en` has no effect.
- R6: An accepted insert and a retirement in the same cycle leave `free_cnt` unchanged.
- R7: A squash request on a non-empty store with no walk active drops `sq_done` after the next edge. On each later cycle, up to `SQ_W` slots are marked squashed and commit-ready, moving from the tail toward the head. The walk stops, raising `sq_done`, when it reaches the slot whose sequence number equals the requested one; that slot and older slots are left unmarked. A request on an empty store is ignored.
- R8: When no slot matches, the walk marks the head slot and then finishes with `sq_done` high.
- R9: While a walk is active (`sq_done` low), `ins_ready` is 0, inserts are dropped and retirement is held. An insert or retirement presented in the same cycle as an accepted squash request is also dropped.
- R10: Head and tail indices wrap modulo `DEPTH`, so entries keep program order across the end of the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | 16 | Sequence number of the inserted instruction |
| ins_pc | input | 32 | PC of the inserted instruction |
| ins_npc | input | 32 | Next-PC of the inserted instruction |
| ins_ready | output | 1 | Store not full and no walk active |
| ret_en | input | 1 | Retire the head if it is commit-ready |
| rdy_set | input | 1 | Set commit-ready on slot `rdy_idx` |
| rdy_idx | input | 3 | Slot index for the commit-ready write |
| sq_req | input | 1 | Start a squash walk |
| sq_seq | input | 16 | Sequence number where the walk stops |
| sq_done | output | 1 | No walk in progress |
| free_cnt | output | 4 | `DEPTH` minus occupancy |
| head_ready | output | 1 | Head present and commit-ready |
| head_squashed | output | 1 | Squashed flag of the head slot |
| head_pc | output | 32 | PC of the head entry |
| head_npc | output | 32 | Next-PC of the head entry |
| head_seq | output | 16 | Sequence number of the head entry |
| tail_pc | output | 32 | PC of the newest entry |
| tail_seq | output | 16 | Sequence number of the newest entry |

## Verification
The checks assume that sequence numbers rise strictly from head to tail, and that a squash number is either present in the store or lower than every entry in it. Under that assumption, every slot the walk marks is younger than the squash point. The directed tests keep to this assumption: each test inserts ascending numbers and squashes either at a stored number or at a value below the oldest entry. The tests never write commit-ready to an empty slot in a way that matters, because an insert clears both flags of its slot.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int SEQ_W = 16;
    localparam int PC_W  = 32;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [PC_W-1:0]  pc_t;

    typedef struct packed {
        seq_t seq;
        pc_t  pc;
        pc_t  npc;
    } rob_payload_t;

    function automatic int unsigned ring_fwd(int unsigned p, int unsigned k, int unsigned n);
        return (p + (k % n)) % n;
    endfunction

    function automatic int unsigned ring_back(int unsigned p, int unsigned k, int unsigned n);
        return (p + n - (k % n)) % n;
    endfunction
endpackage

// File: rtl/rob_store.sv
module rob_store #(
    parameter  int DEPTH = 8,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [PW-1:0]         wr_idx,
    input  rob_pkg::rob_payload_t wr_data,
    input  logic                  rdy_en,
    input  logic [PW-1:0]         rdy_idx,
    input  logic [DEPTH-1:0]      mark_vec,
    input  logic [PW-1:0]         head_idx,
    input  logic [PW-1:0]         tail_idx,
    output rob_pkg::rob_payload_t head_data,
    output rob_pkg::rob_payload_t tail_data,
    output logic                  head_rdy,
    output logic                  head_sq,
    output rob_pkg::seq_t         seq_vec [DEPTH]
);
    rob_pkg::rob_payload_t mem [DEPTH];
    logic [DEPTH-1:0] rdy_vec;
    logic [DEPTH-1:0] sq_vec;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic rdy_q;
        logic sq_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                rdy_q <= 1'b0;
                sq_q  <= 1'b0;
            end else if (wr_en && wr_idx == PW'(i)) begin
                rdy_q <= 1'b0;
                sq_q  <= 1'b0;
            end else begin
                if (mark_vec[i]) begin
                    rdy_q <= 1'b1;
                    sq_q  <= 1'b1;
                end
                if (rdy_en && rdy_idx == PW'(i)) rdy_q <= 1'b1;
            end
        end
        assign rdy_vec[i] = rdy_q;
        assign sq_vec[i]  = sq_q;
        assign seq_vec[i] = mem[i].seq;
    end

    assign head_data = mem[head_idx];
    assign tail_data = mem[tail_idx];
    assign head_rdy  = rdy_vec[head_idx];
    assign head_sq   = sq_vec[head_idx];
endmodule

// File: rtl/rob_squash_walk.sv
module rob_squash_walk #(
    parameter  int DEPTH = 8,
    parameter  int SQ_W  = 2,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic               active,
    input  logic [PW-1:0]      walk_ptr,
    input  logic [PW-1:0]      head_idx,
    input  rob_pkg::seq_t      stop_seq,
    input  rob_pkg::seq_t      seq_vec [DEPTH],
    output logic [DEPTH-1:0]   mark_vec,
    output logic               finish,
    output logic [PW-1:0]      next_ptr
);
    logic          alive;
    logic [PW-1:0] p;

    always_comb begin
        mark_vec = '0;
        finish   = 1'b0;
        alive    = active;
        p        = walk_ptr;
        for (int k = 0; k <= SQ_W; k++) begin
            p = PW'(rob_pkg::ring_back(int'(walk_ptr), unsigned'(k), DEPTH));
            if (alive) begin
                if (seq_vec[p] == stop_seq) begin
                    finish = 1'b1;
                    alive  = 1'b0;
                end else if (k < SQ_W) begin
                    mark_vec[p] = 1'b1;
                    if (p == head_idx) begin
                        finish = 1'b1;
                        alive  = 1'b0;
                    end
                end
            end
        end
        next_ptr = PW'(rob_pkg::ring_back(int'(walk_ptr), SQ_W, DEPTH));
    end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter  int DEPTH = 8,
    parameter  int SQ_W  = 2,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ins_valid,
    input  logic [rob_pkg::SEQ_W-1:0] ins_seq,
    input  logic [rob_pkg::PC_W-1:0]  ins_pc,
    input  logic [rob_pkg::PC_W-1:0]  ins_npc,
    output logic                     ins_ready,
    input  logic                     ret_en,
    input  logic                     rdy_set,
    input  logic [PW-1:0]            rdy_idx,
    input  logic                     sq_req,
    input  logic [rob_pkg::SEQ_W-1:0] sq_seq,
    output logic                     sq_done,
    output logic [CW-1:0]            free_cnt,
    output logic                     head_ready,
    output logic                     head_squashed,
    output logic [rob_pkg::PC_W-1:0]  head_pc,
    output logic [rob_pkg::PC_W-1:0]  head_npc,
    output logic [rob_pkg::SEQ_W-1:0] head_seq,
    output logic [rob_pkg::PC_W-1:0]  tail_pc,
    output logic [rob_pkg::SEQ_W-1:0] tail_seq
);
    logic [PW-1:0]  head_q, tail_q, walk_ptr_q, ins_idx, walk_next;
    logic [CW-1:0]  cnt_q;
    logic           walking_q;
    rob_pkg::seq_t  stop_seq_q;
    rob_pkg::seq_t  seq_vec [DEPTH];
    rob_pkg::rob_payload_t new_ent, head_ent, tail_ent;
    logic [DEPTH-1:0] mark_vec;
    logic           empty, full, sq_start, do_ins, do_ret, head_flag, walk_fin;

    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == CW'(DEPTH));
    assign sq_start = sq_req && !walking_q && !empty;
    assign ins_ready = !full && !walking_q;
    assign do_ins   = ins_valid && ins_ready && !sq_start;
    assign head_ready = !empty && head_flag;
    assign do_ret   = ret_en && head_ready && !walking_q && !sq_start;
    assign ins_idx  = empty ? head_q : PW'(rob_pkg::ring_fwd(int'(tail_q), 1, DEPTH));
    assign new_ent  = '{seq: ins_seq, pc: ins_pc, npc: ins_npc};

    rob_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(do_ins), .wr_idx(ins_idx), .wr_data(new_ent),
        .rdy_en(rdy_set), .rdy_idx(rdy_idx),
        .mark_vec(mark_vec),
        .head_idx(head_q), .tail_idx(tail_q),
        .head_data(head_ent), .tail_data(tail_ent),
        .head_rdy(head_flag), .head_sq(head_squashed),
        .seq_vec(seq_vec)
    );

    rob_squash_walk #(.DEPTH(DEPTH), .SQ_W(SQ_W)) u_walk (
        .active(walking_q), .walk_ptr(walk_ptr_q), .head_idx(head_q),
        .stop_seq(stop_seq_q), .seq_vec(seq_vec),
        .mark_vec(mark_vec), .finish(walk_fin), .next_ptr(walk_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q     <= '0;
            tail_q     <= '0;
            cnt_q      <= '0;
            walking_q  <= 1'b0;
            walk_ptr_q <= '0;
            stop_seq_q <= '0;
        end else begin
            if (do_ins) tail_q <= ins_idx;
            if (do_ret) head_q <= PW'(rob_pkg::ring_fwd(int'(head_q), 1, DEPTH));
            unique case ({do_ins, do_ret})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
            if (sq_start) begin
                walking_q  <= 1'b1;
                walk_ptr_q <= tail_q;
                stop_seq_q <= sq_seq;
            end else if (walking_q) begin
                if (walk_fin) walking_q <= 1'b0;
                else          walk_ptr_q <= walk_next;
            end
        end
    end

    assign sq_done  = !walking_q;
    assign free_cnt = CW'(DEPTH) - cnt_q;
    assign head_pc  = head_ent.pc;
    assign head_npc = head_ent.npc;
    assign head_seq = head_ent.seq;
    assign tail_pc  = tail_ent.pc;
    assign tail_seq = tail_ent.seq;
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      ins_valid,
    input logic                      ins_ready,
    input logic                      ret_en,
    input logic                      sq_req,
    input logic                      sq_done,
    input logic [CW-1:0]             free_cnt,
    input logic                      head_ready,
    input logic [rob_pkg::SEQ_W-1:0] tail_seq
);
    assert_free_range_R1: assert property (@(posedge clk) disable iff (rst)
        free_cnt <= CW'(DEPTH));

    assert_insert_dec_R2: assert property (@(posedge clk) disable iff (rst)
        ins_valid && ins_ready && !head_ready && !sq_req |=> free_cnt == $past(free_cnt) - CW'(1));

    assert_blocked_insert_R3: assert property (@(posedge clk) disable iff (rst)
        !ins_ready |=> $stable(tail_seq));

    assert_ready_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
        head_ready |-> free_cnt != CW'(DEPTH));

    assert_idle_retire_R5: assert property (@(posedge clk) disable iff (rst)
        ret_en && !head_ready && !(ins_valid && ins_ready) |=> $stable(free_cnt));

    assert_pair_hold_R6: assert property (@(posedge clk) disable iff (rst)
        ins_valid && ins_ready && ret_en && head_ready && sq_done && !sq_req |=> $stable(free_cnt));

    assert_walk_start_R7: assert property (@(posedge clk) disable iff (rst)
        sq_req && sq_done && free_cnt != CW'(DEPTH) |=> !sq_done);

    assert_walk_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        !sq_done |=> $stable(free_cnt));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ret_en(ret_en), .sq_req(sq_req), .sq_done(sq_done), .free_cnt(free_cnt),
    .head_ready(head_ready), .tail_seq(tail_seq)
);

// File: tb/test_rob_core.sv
`timescale 1ns/1ps
module test_rob_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 0, ret_en = 0, rdy_set = 0, sq_req = 0;
    logic [15:0] ins_seq = 0, sq_seq = 0;
    logic [31:0] ins_pc = 0, ins_npc = 0;
    logic [2:0]  rdy_idx = 0;
    logic        ins_ready, sq_done, head_ready, head_squashed;
    logic [3:0]  free_cnt;
    logic [31:0] head_pc, head_npc, tail_pc;
    logic [15:0] head_seq, tail_seq;
    int checks = 0;
    int errors = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    rob_core #(.DEPTH(8), .SQ_W(2)) i_rob_core (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_seq(ins_seq),
        .ins_pc(ins_pc), .ins_npc(ins_npc), .ins_ready(ins_ready),
        .ret_en(ret_en), .rdy_set(rdy_set), .rdy_idx(rdy_idx),
        .sq_req(sq_req), .sq_seq(sq_seq), .sq_done(sq_done),
        .free_cnt(free_cnt), .head_ready(head_ready), .head_squashed(head_squashed),
        .head_pc(head_pc), .head_npc(head_npc), .head_seq(head_seq),
        .tail_pc(tail_pc), .tail_seq(tail_seq)
    );

    function automatic logic [31:0] pc_of(input logic [15:0] s);
        return 32'h1000 + {14'd0, s, 2'b00};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [15:0] s);
        ins_valid = 1; ins_seq = s; ins_pc = pc_of(s); ins_npc = pc_of(s) + 4;
        step();
        ins_valid = 0;
    endtask

    task automatic retire();
        ret_en = 1; step(); ret_en = 0;
    endtask

    task automatic mark_ready(input int idx);
        rdy_set = 1; rdy_idx = 3'(idx); step(); rdy_set = 0;
    endtask

    task automatic t_reset();
        chk("R1 free", 64'(free_cnt), 8);
        chk("R1 head_ready", 64'(head_ready), 0);
        chk("R1 sq_done", 64'(sq_done), 1);
        chk("R1 ins_ready", 64'(ins_ready), 1);
    endtask

    task automatic t_insert();
        push(10);
        chk("R2 head_seq first", 64'(head_seq), 10);
        chk("R2 tail_seq first", 64'(tail_seq), 10);
        chk("R2 free", 64'(free_cnt), 7);
        push(11); push(12);
        chk("R2 tail_seq", 64'(tail_seq), 12);
        chk("R2 tail_pc", 64'(tail_pc), 64'(pc_of(12)));
        chk("R2 head_seq kept", 64'(head_seq), 10);
        chk("R2 head_npc", 64'(head_npc), 64'(pc_of(10) + 4));
        chk("R2 head_pc", 64'(head_pc), 64'(pc_of(10)));
    endtask

    task automatic t_ready_retire();
        chk("R4 not ready", 64'(head_ready), 0);
        retire();
        chk("R5 retire ignored", 64'(free_cnt), 5);
        chk("R5 head kept", 64'(head_seq), 10);
        mark_ready(1);
        chk("R4 non-head ready", 64'(head_ready), 0);
        mark_ready(0);
        chk("R4 head ready", 64'(head_ready), 1);
        retire();
        chk("R5 head advance", 64'(head_seq), 11);
        chk("R5 free up", 64'(free_cnt), 6);
        chk("R4 next ready", 64'(head_ready), 1);
        retire();
        chk("R5 head 12", 64'(head_seq), 12);
        chk("R4 12 not ready", 64'(head_ready), 0);
    endtask

    task automatic t_pair();
        mark_ready(2);
        ins_valid = 1; ins_seq = 13; ins_pc = pc_of(13); ins_npc = pc_of(13) + 4;
        ret_en = 1;
        step();
        ins_valid = 0; ret_en = 0;
        chk("R6 free same", 64'(free_cnt), 7);
        chk("R6 head", 64'(head_seq), 13);
        chk("R6 tail", 64'(tail_seq), 13);
    endtask

    task automatic t_full_wrap();
        for (int s = 14; s <= 20; s++) push(16'(s));
        chk("R3 free zero", 64'(free_cnt), 0);
        chk("R3 ins_ready low", 64'(ins_ready), 0);
        chk("R10 tail wrapped", 64'(tail_seq), 20);
        push(21);
        chk("R3 free kept", 64'(free_cnt), 0);
        chk("R3 tail kept", 64'(tail_seq), 20);
        for (int i = 0; i < 8; i++) mark_ready(i);
        for (int i = 0; i < 8; i++) begin
            chk("R10 order", 64'(head_seq), 64'(13 + i));
            retire();
        end
        chk("R10 drained", 64'(free_cnt), 8);
        chk("R4 empty not ready", 64'(head_ready), 0);
    endtask

    task automatic t_squash_match();
        for (int s = 30; s <= 34; s++) push(16'(s));
        sq_req = 1; sq_seq = 31; step(); sq_req = 0;
        chk("R7 walk started", 64'(sq_done), 0);
        chk("R9 ins_ready low", 64'(ins_ready), 0);
        ins_valid = 1; ins_seq = 99; ret_en = 1;
        step();
        ins_valid = 0; ret_en = 0;
        chk("R7 still walking", 64'(sq_done), 0);
        chk("R9 free frozen", 64'(free_cnt), 3);
        step();
        chk("R7 walk done", 64'(sq_done), 1);
        chk("R9 no insert", 64'(tail_seq), 34);
        chk("R7 older untouched", 64'(head_ready), 0);
        mark_ready(3); mark_ready(4);
        chk("R7 30 not squashed", 64'(head_squashed), 0);
        retire();
        chk("R7 31 not squashed", 64'(head_squashed), 0);
        retire();
        for (int s = 32; s <= 34; s++) begin
            chk("R7 younger ready", 64'(head_ready), 1);
            chk("R7 younger squashed", 64'(head_squashed), 1);
            retire();
        end
        chk("R7 drained", 64'(free_cnt), 8);
    endtask

    task automatic t_squash_head();
        push(40); push(41); push(42);
        sq_req = 1; sq_seq = 5; step(); sq_req = 0;
        step();
        chk("R8 walking", 64'(sq_done), 0);
        step();
        chk("R8 done at head", 64'(sq_done), 1);
        for (int s = 40; s <= 42; s++) begin
            chk("R8 squashed", 64'(head_squashed), 1);
            chk("R8 ready", 64'(head_ready), 1);
            retire();
        end
        chk("R8 drained", 64'(free_cnt), 8);
    endtask

    task automatic t_squash_tail_and_empty();
        sq_req = 1; sq_seq = 3; step(); sq_req = 0;
        chk("R7 empty request ignored", 64'(sq_done), 1);
        push(50);
        sq_req = 1; sq_seq = 50; step(); sq_req = 0;
        chk("R7 tail match started", 64'(sq_done), 0);
        step();
        chk("R7 tail match done", 64'(sq_done), 1);
        chk("R7 tail not marked", 64'(head_squashed), 0);
        chk("R7 tail not ready", 64'(head_ready), 0);
        mark_ready(3);
        retire();
        chk("R5 final drain", 64'(free_cnt), 8);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_insert();
        t_ready_retire();
        t_pair();
        t_full_wrap();
        t_squash_match();
        t_squash_head();
        t_squash_tail_and_empty();
        finish_run();
    end
endmodule